// File: doc/BRIEF.md
# Two-Modulus Swallow Divider

This block is the feedback divider of a frequency synthesizer loop that uses an external two-modulus prescaler. Its clock input is the prescaler output. It counts rising edges of that clock with a main down counter of `NW` bits and a swallow counter of `AW` bits. While the swallow counter is non-zero, it raises a modulus-control line that tells the prescaler to divide by P+1 instead of P. Over one main cycle the oscillator is therefore divided by N·P+A, and not by the plain N·P.

At the end of every main cycle the block emits a single-edge pulse towards the phase detector. Both counters then reload together from the program word, which comes from the programming latches. Because the reload happens only at that cycle boundary, new N and A values may be written at any moment without producing a truncated or stretched cycle. A swallow value that is not smaller than the effective N is an illegal setting. The block then holds modulus control low for the whole cycle and divides by N alone.

Top module: `swc_divider`

## Requirements
- R1: While `rst_n` is low, `fv` is 1 and `mod_hi` is 0. The first rising edge of `fin_clk` after reset starts a new cycle.
- R2: `fv` is high for exactly one `fin_clk` period at the end of each cycle. A cycle lasts Neff rising edges, where Neff is `n_word` if `n_word` is non-zero and 1 if it is zero.
- R3: When the sampled `a_word` is less than Neff, `mod_hi` is 1 during the first `a_word` periods of the cycle and 0 during the rest.
- R4: When the sampled `a_word` is greater than or equal to Neff, `mod_hi` stays 0 for the whole cycle and the cycle still lasts Neff periods.
- R5: `n_word` and `a_word` are sampled only on the rising edge at which `fv` is high. A change in the middle of a cycle affects neither the current cycle's length nor its modulus-control pattern.
- R6: An `n_word` of 0 or 1 gives a cycle of one period, so `fv` stays high on every period and `mod_hi` stays 0.
- R7: With a prescaler that divides by P while `mod_hi` is 0 and by P+1 while it is 1, a legal cycle spans Neff·P + `a_word` oscillator periods.
- R8: `mod_hi` is never 1 in a period where `fv` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fin_clk | input | 1 | Prescaler output; counting happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_word | input | NW (10) | Latched main divide value N |
| a_word | input | AW (7) | Latched swallow value A |
| mod_hi | output | 1 | Modulus control: 1 selects prescaler ratio P+1 |
| fv | output | 1 | Divided output, one period high per cycle |

## Verification
The bound checker watches four things on every edge. It checks that `fv` and `mod_hi` are never high together. It checks that `mod_hi` rises only directly after an `fv` period. It checks that a cycle with N above one ends its pulse after one period, while N of zero or one keeps `fv` high. It checks that an illegal swallow setting keeps modulus control low until the next boundary. Other properties depend on how stimulus unfolds over time, and only the bench's scenarios can show them. These are the exact swallow count per cycle, the full N·P+A oscillator period, and the deferral of programming changes written mid-cycle. The bench checks them against its edge-indexed model, including at A = N−1, at the largest N and A, and across a reprogram in mid-cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;
   // modulus-control encoding toward the prescaler
   typedef enum logic [0:0] {
      MOD_LOW  = 1'b0,   // prescaler divides by P
      MOD_HIGH = 1'b1    // prescaler divides by P+1
   } swc_mod_e;

   // smallest effective main divide value
   localparam int unsigned SWC_NEFF_MIN = 1;
endpackage

// File: rtl/swc_down_counter.sv
module swc_down_counter #(
   parameter int W        = 10,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_next,
   output logic         is_zero
);
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] dec_val;

   generate
      if (W < 1) begin : g_bad_w
         $error("swc_down_counter: W must be at least 1");
      end
      if (SATURATE) begin : g_sat
         // stop at zero until the next reload
         assign dec_val = (cnt == ZERO) ? ZERO : cnt - ONE;
      end else begin : g_wrap
         assign dec_val = cnt - ONE;
      end
   endgenerate

   assign is_zero  = (cnt == ZERO);
   assign cnt_next = reload ? reload_val : dec_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= ZERO;
      else        cnt <= cnt_next;
   end
endmodule

// File: rtl/swc_prog_check.sv
module swc_prog_check #(
   parameter int NW = 10,
   parameter int AW = 7
) (
   input  logic [NW-1:0] n_word,
   input  logic [AW-1:0] a_word,
   output logic [NW-1:0] n_reload,
   output logic [AW-1:0] a_reload,
   output logic          legal
);
   localparam logic [NW-1:0] N_ZERO = '0;
   localparam logic [NW-1:0] N_ONE  = {{(NW-1){1'b0}}, 1'b1};

   logic [NW-1:0] a_ext;

   generate
      if (AW >= NW) begin : g_bad_aw
         $error("swc_prog_check: AW must be smaller than NW");
      end
   endgenerate

   assign a_ext = {{(NW-AW){1'b0}}, a_word};

   // main counter runs Neff-1 .. 0; N of zero acts as one
   assign n_reload = (n_word == N_ZERO) ? N_ZERO : n_word - N_ONE;
   // a < Neff  <=>  a <= Neff-1
   assign legal    = (a_ext <= n_reload);
   assign a_reload = legal ? a_word : '0;
endmodule

// File: rtl/swc_divider.sv
module swc_divider #(
   parameter int NW      = 10,
   parameter int AW      = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          fin_clk,
   input  logic          rst_n,
   input  logic [NW-1:0] n_word,
   input  logic [AW-1:0] a_word,
   output logic          mod_hi,
   output logic          fv
);
   import swc_pkg::*;

   localparam int NMAX = (1 << NW) - 1;

   logic [NW-1:0] n_reload, n_cnt, n_next;
   logic [AW-1:0] a_reload, a_cnt, a_next;
   logic          legal, n_zero, a_zero, terminal;

   generate
      if (NW < 2) begin : g_bad_nw
         $error("swc_divider: NW must be at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("swc_divider: AW must be at least 1");
      end
      if (NMAX < int'(SWC_NEFF_MIN)) begin : g_bad_range
         $error("swc_divider: N range empty");
      end
   endgenerate

   swc_prog_check #(.NW(NW), .AW(AW)) u_prog (
      .n_word  (n_word),
      .a_word  (a_word),
      .n_reload(n_reload),
      .a_reload(a_reload),
      .legal   (legal)
   );

   // both counters reload on the same terminal edge
   assign terminal = n_zero;

   swc_down_counter #(.W(NW), .SATURATE(1'b0)) u_ncnt (
      .clk       (fin_clk),
      .rst_n     (rst_n),
      .reload    (terminal),
      .reload_val(n_reload),
      .cnt       (n_cnt),
      .cnt_next  (n_next),
      .is_zero   (n_zero)
   );

   swc_down_counter #(.W(AW), .SATURATE(1'b1)) u_acnt (
      .clk       (fin_clk),
      .rst_n     (rst_n),
      .reload    (terminal),
      .reload_val(a_reload),
      .cnt       (a_cnt),
      .cnt_next  (a_next),
      .is_zero   (a_zero)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         swc_mod_e mod_q;
         logic     fv_q;
         always_ff @(posedge fin_clk or negedge rst_n) begin
            if (!rst_n) begin
               fv_q  <= 1'b1;
               mod_q <= MOD_LOW;
            end else begin
               fv_q  <= (n_next == '0);
               mod_q <= (a_next != '0) ? MOD_HIGH : MOD_LOW;
            end
         end
         assign fv     = fv_q;
         assign mod_hi = (mod_q == MOD_HIGH);
      end else begin : g_out_comb
         assign fv     = n_zero;
         assign mod_hi = !a_zero;
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = ^{legal, n_cnt, a_cnt};
endmodule

// File: rtl/swc_divider_chk.sv
module swc_divider_chk #(
   parameter int NW = 10,
   parameter int AW = 7
) (
   input logic          fin_clk,
   input logic          rst_n,
   input logic [NW-1:0] n_word,
   input logic [AW-1:0] a_word,
   input logic          mod_hi,
   input logic          fv
);
   logic illegal_q;
   int   neff;

   assign neff = (n_word == '0) ? 1 : int'(n_word);

   always_ff @(posedge fin_clk or negedge rst_n) begin
      if (!rst_n)  illegal_q <= 1'b0;
      else if (fv) illegal_q <= (int'(a_word) >= neff);
   end

   // R8
   fv_mod_excl_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
      fv |-> !mod_hi);

   // R3
   mod_rise_after_fv_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
      $rose(mod_hi) |-> $past(fv));

   // R2
   fv_single_period_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
      (fv && neff > 1) |=> !fv);

   // R6
   fv_div_one_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
      (fv && neff == 1) |=> fv);

   // R4
   illegal_mod_low_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
      illegal_q |-> !mod_hi);
endmodule

bind swc_divider swc_divider_chk #(.NW(NW), .AW(AW)) u_chk (.*);

// File: tb/sim_swc_divider.sv
module sim_swc_divider;
   localparam int NW = 10;
   localparam int AW = 7;
   localparam int P  = 8;

   logic          fin_clk = 1'b0;
   logic          rst_n   = 1'b0;
   logic [NW-1:0] n_word  = '0;
   logic [AW-1:0] a_word  = '0;
   logic          mod_hi, fv;

   int compared = 0, mismatched = 0, cycles = 0;
   int k = 0, L = 1, S = 0, vco = 0;
   bit started = 0;
   string tag = "R1";

   always #2.5 fin_clk = ~fin_clk;

   swc_divider #(.NW(NW), .AW(AW)) u0 (.*);

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // behavioural model: position inside the current cycle
   always @(posedge fin_clk) begin
      cycles++;
      if (!rst_n) begin
         k = 0; L = 1; S = 0;
      end else if (k == L - 1) begin
         L = (n_word == 0) ? 1 : int'(n_word);
         S = (int'(a_word) < L) ? int'(a_word) : 0;
         k = 0;
      end else begin
         k++;
      end
   end

   always @(negedge fin_clk) begin
      if (rst_n) begin
         check({tag, " fv"},  int'(fv),     int'(k == L - 1));
         check({tag, " mod"}, int'(mod_hi), int'(k < S));
         vco += mod_hi ? P + 1 : P;
         if (k == L - 1) begin
            // R7 oscillator periods per cycle
            if (started) check("R7 period", vco, L * P + S);
            vco = 0;
            started = 1;
         end
      end
   end

   task automatic run(input int n, input int a, input int edges, input string t);
      @(negedge fin_clk);
      n_word = NW'(n); a_word = AW'(a); tag = t;
      repeat (edges) @(negedge fin_clk);
   endtask

   initial begin
      fork
         begin
            n_word = 10'd10; a_word = 7'd3;
            repeat (3) @(negedge fin_clk);
            check("R1 fv", int'(fv), 1);
            check("R1 mod", int'(mod_hi), 0);
            rst_n = 1'b1;
            tag = "R2/R3";
            repeat (40) @(negedge fin_clk);
            run(20, 0, 45, "R2");
            run(8, 7, 30, "R3");
            run(5, 5, 20, "R4");
            run(4, 100, 20, "R4");
            run(1, 0, 6, "R6");
            run(0, 0, 6, "R6");
            run(0, 3, 6, "R6");
            run(12, 4, 17, "R5");
            // change in mid-cycle, must wait for the boundary
            run(6, 2, 3, "R5");
            run(3, 1, 2, "R5");
            run(9, 8, 30, "R5");
            run(1023, 127, 2100, "R2/R3");
         end
         begin
            repeat (150000) @(posedge fin_clk);
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule